// File: doc/BRIEF.md
# Asynchronous Memory Bus Front End

This block sits behind the pads of an asynchronous byte-wide memory port. It takes the three active-low bus strobes (chip enable, output enable, write enable), the address bus and the incoming data bus, samples all of them with a fast internal clock, and turns them into clean single-clock events for the storage logic behind it. Each completed write appears as a one-cycle valid pulse with a latched address and data. A read appears as an output-enable level for the bidirectional data pads, a one-cycle start pulse and a synchronised read address.

Every input first passes through a two-flop synchroniser. Each strobe then goes through a persistence filter, so that a strobe pulse shorter than a programmable number of clock cycles never starts a bus operation. The block also reports standby while chip enable is high. It raises an automatic-standby flag once the strobes and the address have been quiet for a programmable number of cycles. That flag does not stop a read that is still driving the bus.

Top module: `abf_bus_front`

## Requirements
- R1: While reset is held and in the first cycle after it is released, standby is 1 and dq_oe, rd_strobe, wr_valid and auto_standby are 0.
- R2: A strobe level change reaches the decode logic 2 + GLITCH_CYC clock cycles after it is applied. A strobe pulse that lasts fewer than GLITCH_CYC samples is discarded entirely. A pulse of GLITCH_CYC samples or more is accepted.
- R3: The write address is the synchronised address at the moment the later of chip enable or write enable goes low. Later address changes during the same write are not used.
- R4: The write data is the last synchronised data seen while both chip enable and write enable were low, which is the data at the earlier rising strobe. The end of the filtered write phase produces exactly one wr_valid pulse of one cycle, carrying wr_addr and wr_data.
- R5: If output enable is low at any point during the filtered write phase, that write produces no wr_valid pulse.
- R6: dq_oe is 1 exactly while the filtered strobes show chip enable low, output enable low and write enable high. rd_strobe pulses for one cycle when that condition starts, and rd_addr follows the synchronised address.
- R7: While the filtered chip enable is high, standby is 1 and dq_oe is 0. Toggling output enable or write enable in that state produces no read pulse and no write pulse.
- R8: auto_standby rises after IDLE_CYC consecutive cycles with no change on the synchronised strobes or address. It falls on the cycle after any such change, and it never forces dq_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Data arriving on the bus during writes |
| wr_valid | output | 1 | One-cycle pulse per accepted write |
| wr_addr | output | ADDR_W | Address of the last accepted write |
| wr_data | output | DATA_W | Data of the last accepted write |
| rd_strobe | output | 1 | One-cycle pulse at the start of a read |
| rd_addr | output | ADDR_W | Synchronised address for read lookup |
| dq_oe | output | 1 | Drive enable for the data pads |
| standby | output | 1 | Chip enable (filtered) is inactive |
| auto_standby | output | 1 | Bus quiet for IDLE_CYC cycles |

## Verification
The bench uses GLITCH_CYC = 3, IDLE_CYC = 20, ADDR_W = 12 and DATA_W = 8. A glitch threshold of three makes the limiting case exact: a two-sample write-enable pulse must vanish and a three-sample one must complete a write. The short idle threshold lets the automatic standby flag rise, and then be cleared, during a single held read. The narrow buses keep the chosen address and data patterns readable, and the strobe orderings for both write-start cases are driven explicitly.

// File: rtl/abf_pkg.sv
package abf_pkg;
  localparam int NSTB   = 3;
  localparam int STB_CE = 0;
  localparam int STB_OE = 1;
  localparam int STB_WE = 2;
  typedef logic [NSTB-1:0] stb_t;
endpackage

// File: rtl/abf_sync.sv
module abf_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/abf_deglitch.sv
module abf_deglitch #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(GLITCH_CYC - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] run_q, run_d;

  always_comb begin
    lvl_d = lvl_q;
    run_d = '0;
    if (lvl_i != lvl_q) begin
      if (run_q == RUN_LAST) lvl_d = lvl_i;
      else                   run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

  assign lvl_o = lvl_q;

  // R2: the filtered level only moves after a full persistence run
  p_filter_persist_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(run_q) == RUN_LAST));
endmodule

// File: rtl/abf_idle.sv
module abf_idle #(
  parameter int W = 1,
  parameter int IDLE_CYC = 30,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] watch_i,
  output logic         idle_o
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(IDLE_CYC);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          moved;

  assign moved = (watch_i != prev_q);

  always_comb begin
    cnt_d = cnt_q;
    if (moved)                cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      prev_q <= watch_i;
      cnt_q  <= cnt_d;
    end
  end

  assign idle_o = (cnt_q == CNT_TOP);

  // R8: any bus movement clears the idle flag on the next cycle
  p_idle_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    moved |=> !idle_o);
  // R8: the flag rises only after a full quiet count
  p_idle_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> ($past(cnt_q) == CW'(IDLE_CYC - 1)));
endmodule

// File: rtl/abf_bus_front.sv
module abf_bus_front
  import abf_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 4,
  parameter int IDLE_CYC   = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_strobe,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dq_oe,
  output logic              standby,
  output logic              auto_standby
);
  localparam int BUS_W = ADDR_W + DATA_W;

  stb_t              stb_raw, stb_s2, stb_f;
  logic [BUS_W-1:0]  bus_s2;
  logic [ADDR_W-1:0] addr_s2;
  logic [DATA_W-1:0] data_s2;

  assign stb_raw = {bus_we_n, bus_oe_n, bus_ce_n};

  abf_sync #(.W(NSTB), .RST_VAL({NSTB{1'b1}})) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d_i(stb_raw), .q_o(stb_s2));

  abf_sync #(.W(BUS_W), .RST_VAL({BUS_W{1'b0}})) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d_i({bus_addr, bus_wdata}), .q_o(bus_s2));

  assign addr_s2 = bus_s2[BUS_W-1:DATA_W];
  assign data_s2 = bus_s2[DATA_W-1:0];

  for (genvar gi = 0; gi < NSTB; gi++) begin : gen_dg
    abf_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_dg (
      .clk(clk), .rst_n(rst_n), .lvl_i(stb_s2[gi]), .lvl_o(stb_f[gi]));
  end

  abf_idle #(
    .W(NSTB + ADDR_W), .IDLE_CYC(IDLE_CYC),
    .RST_VAL({{NSTB{1'b1}}, {ADDR_W{1'b0}}})
  ) u_idle (
    .clk(clk), .rst_n(rst_n), .watch_i({stb_s2, addr_s2}), .idle_o(auto_standby));

  // decode
  logic raw_wr, ph, rd_act;
  assign raw_wr = !stb_s2[STB_CE] && !stb_s2[STB_WE];
  assign ph     = !stb_f[STB_CE]  && !stb_f[STB_WE];
  assign rd_act = !stb_f[STB_CE]  && !stb_f[STB_OE] && stb_f[STB_WE];

  logic              raw_wr_q, ph_q, bad_q, bad_d, rd_q, wv_q, wv_d;
  logic [ADDR_W-1:0] ahold_q, ahold_d, wa_q, wa_d;
  logic [DATA_W-1:0] dhold_q, dhold_d, wd_q, wd_d;

  always_comb begin
    ahold_d = ahold_q;
    dhold_d = dhold_q;
    bad_d   = bad_q;
    wv_d    = 1'b0;
    wa_d    = wa_q;
    wd_d    = wd_q;
    if (raw_wr && !raw_wr_q) ahold_d = addr_s2;
    if (raw_wr)              dhold_d = data_s2;
    if (ph && !ph_q)                    bad_d = !stb_f[STB_OE];
    else if (ph && !stb_f[STB_OE])      bad_d = 1'b1;
    if (!ph && ph_q && !bad_q) begin
      wv_d = 1'b1;
      wa_d = ahold_q;
      wd_d = dhold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_wr_q <= 1'b0;
      ph_q     <= 1'b0;
      bad_q    <= 1'b0;
      rd_q     <= 1'b0;
      wv_q     <= 1'b0;
      ahold_q  <= '0;
      dhold_q  <= '0;
      wa_q     <= '0;
      wd_q     <= '0;
    end else begin
      raw_wr_q <= raw_wr;
      ph_q     <= ph;
      bad_q    <= bad_d;
      rd_q     <= rd_act;
      wv_q     <= wv_d;
      ahold_q  <= ahold_d;
      dhold_q  <= dhold_d;
      wa_q     <= wa_d;
      wd_q     <= wd_d;
    end
  end

  assign wr_valid  = wv_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign dq_oe     = rd_act;
  assign rd_strobe = rd_act && !rd_q;
  assign rd_addr   = addr_s2;
  assign standby   = stb_f[STB_CE];

  // R4: a write pulse lasts exactly one cycle
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R4: a write pulse only follows a filtered write phase
  p_wr_after_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(ph_q));
  // R7: pads are never driven in standby
  p_standby_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !dq_oe);
  // R6: the read start pulse is a single cycle
  p_rd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);
endmodule

// File: tb/abf_bus_front_tb.sv
module abf_bus_front_tb;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int G  = 3;
  localparam int IDLE = 20;

  logic clk, rst_n;
  logic ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic wr_valid, rd_strobe, dq_oe, standby, auto_standby;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;

  abf_bus_front #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(G), .IDLE_CYC(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_wdata(wdata), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_strobe(rd_strobe), .rd_addr(rd_addr), .dq_oe(dq_oe),
    .standby(standby), .auto_standby(auto_standby));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped at every rising edge
  logic [2:0]    m_s1, m_s2, m_prev, m_filt;
  logic [AW-1:0] m_s1a, m_s2a, m_preva, m_ahold, m_wa;
  logic [DW-1:0] m_s1d, m_s2d, m_dhold, m_wd;
  int            m_run [3];
  int            m_cnt;
  logic          m_rawd, m_phd, m_bad, m_wv, m_rdd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 3'b111; m_s2 = 3'b111; m_prev = 3'b111; m_filt = 3'b111;
      m_s1a = '0; m_s2a = '0; m_preva = '0; m_ahold = '0; m_wa = '0;
      m_s1d = '0; m_s2d = '0; m_dhold = '0; m_wd = '0;
      foreach (m_run[i]) m_run[i] = 0;
      m_cnt = 0; m_rawd = 0; m_phd = 0; m_bad = 0; m_wv = 0; m_rdd = 0;
    end else begin
      logic raw, ph, rd;
      logic [2:0] nf;
      raw = !m_s2[0] && !m_s2[2];
      ph  = !m_filt[0] && !m_filt[2];
      rd  = !m_filt[0] && !m_filt[1] && m_filt[2];
      m_wv = 0;
      if (!ph && m_phd && !m_bad) begin m_wv = 1; m_wa = m_ahold; m_wd = m_dhold; end
      if (ph && !m_phd) m_bad = !m_filt[1];
      else if (ph && !m_filt[1]) m_bad = 1;
      if (raw && !m_rawd) m_ahold = m_s2a;
      if (raw) m_dhold = m_s2d;
      m_rawd = raw; m_phd = ph; m_rdd = rd;
      nf = m_filt;
      for (int i = 0; i < 3; i++) begin
        if (m_s2[i] != m_filt[i]) begin
          if (m_run[i] == G - 1) begin nf[i] = m_s2[i]; m_run[i] = 0; end
          else m_run[i]++;
        end else m_run[i] = 0;
      end
      m_filt = nf;
      if ({m_s2, m_s2a} != {m_prev, m_preva}) m_cnt = 0;
      else if (m_cnt < IDLE) m_cnt++;
      m_prev = m_s2; m_preva = m_s2a;
      m_s2 = m_s1; m_s2a = m_s1a; m_s2d = m_s1d;
      m_s1 = {we_n, oe_n, ce_n}; m_s1a = addr; m_s1d = wdata;
    end
  end

  // per-cycle comparison and event monitor, away from the active edge
  int nwr = 0, nrd = 0;
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_rd;
      e_rd = !m_filt[0] && !m_filt[1] && m_filt[2];
      chk("R4 wr_valid", wr_valid, m_wv);
      chk("R4 wr_addr", wr_addr, m_wa);
      chk("R4 wr_data", wr_data, m_wd);
      chk("R6 dq_oe", dq_oe, e_rd);
      chk("R6 rd_strobe", rd_strobe, e_rd && !m_rdd);
      chk("R6 rd_addr", rd_addr, m_s2a);
      chk("R7 standby", standby, m_filt[0]);
      chk("R8 auto_standby", auto_standby, m_cnt == IDLE);
      if (wr_valid) begin nwr++; last_wa = wr_addr; last_wd = wr_data; end
      if (rd_strobe) nrd++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; wdata = '0;
    step(4);
    chk("R1 standby in reset", standby, 1);
    chk("R1 dq_oe in reset", dq_oe, 0);
    rst_n = 1;
    step(1);
    chk("R1 standby", standby, 1);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 auto_standby", auto_standby, 0);
    chk("R1 rd_strobe", rd_strobe, 0);

    // R3/R4: chip enable first, write enable falls later
    w0 = nwr;
    ce_n = 0; addr = 12'h123; step(8);
    addr = 12'h456; wdata = 8'h5A; step(8);
    we_n = 0; step(8);
    we_n = 1; step(3);
    wdata = 8'hFF; addr = 12'h789; step(8);
    ce_n = 1; step(10);
    chk("R4 one write", nwr - w0, 1);
    chk("R3 addr at later fall", last_wa, 12'h456);
    chk("R4 data at first rise", last_wd, 8'h5A);

    // R3/R4/R7: write enable first (ignored in standby), chip enable rises first
    w0 = nwr;
    we_n = 0; addr = 12'h0AA; wdata = 8'h33; step(8);
    chk("R7 no write while ce high", nwr - w0, 0);
    ce_n = 0; step(8);
    ce_n = 1; step(2);
    wdata = 8'h44; step(8);
    we_n = 1; step(10);
    chk("R4 second write", nwr - w0, 1);
    chk("R3 addr at ce fall", last_wa, 12'h0AA);
    chk("R4 data at ce rise", last_wd, 8'h33);

    // R2: two-sample write pulse discarded, three-sample pulse accepted
    w0 = nwr;
    ce_n = 0; addr = 12'h321; wdata = 8'h77; step(8);
    we_n = 0; step(2); we_n = 1; step(12);
    chk("R2 short pulse dropped", nwr - w0, 0);
    we_n = 0; step(3); we_n = 1; step(12);
    ce_n = 1; step(10);
    chk("R2 threshold pulse kept", nwr - w0, 1);
    chk("R2 kept pulse addr", last_wa, 12'h321);

    // R5: output enable low during a write suppresses it
    w0 = nwr;
    ce_n = 0; addr = 12'h0F0; step(8);
    we_n = 0; step(8);
    oe_n = 0; step(6); oe_n = 1; step(6);
    we_n = 1; step(10);
    ce_n = 1; step(10);
    chk("R5 write with oe low dropped", nwr - w0, 0);

    // R6/R8: read, held long enough to go idle
    r0 = nrd;
    addr = 12'h2B0; ce_n = 0; step(8);
    oe_n = 0; step(8);
    chk("R6 one read pulse", nrd - r0, 1);
    chk("R6 dq_oe during read", dq_oe, 1);
    chk("R6 rd_addr", rd_addr, 12'h2B0);
    step(IDLE + 6);
    chk("R8 idle flag raised", auto_standby, 1);
    chk("R8 read still driving", dq_oe, 1);
    addr = 12'h2B1; step(4);
    chk("R8 idle flag cleared", auto_standby, 0);
    oe_n = 1; ce_n = 1; step(10);
    chk("R7 pads off in standby", dq_oe, 0);

    // R7: strobes toggled while chip enable is high
    w0 = nwr; r0 = nrd;
    oe_n = 0; step(8); we_n = 0; step(8); oe_n = 1; step(8); we_n = 1; step(10);
    chk("R7 no read in standby", nrd - r0, 0);
    chk("R7 no write in standby", nwr - w0, 0);
    chk("R7 standby flag", standby, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule